// File: doc/BRIEF.md
# Data-Strobe Link Character Serializer

This block turns a stream of link tokens into the two-wire data-strobe signalling of a serial point-to-point link. A token arrives on a set of field inputs qualified by a valid flag. The fields select a time code, a flow-control token, a flow-control token paired with a character, an end-of-packet marker or an ordinary 8-bit character. The block expands each token into one or two link characters. It serializes them with a parity bit that spans character boundaries and drives one bit per pulse of an external bit-rate enable. The strobe line is generated so that exactly one of the two lines toggles in each bit period.

The surrounding link logic keeps a token on the inputs until the block pulses its consumed output. If no token is waiting when the next character has to start, the block fills the gap with a NULL. When transmit enable is removed, the lines are brought to zero over two bit periods without ever toggling both at once. When enable returns, the first thing sent is always a NULL.

Top module: `ds_serializer`

## Requirements
- R1: A data character is 10 bits in this transmission order: parity, a flag of 0, then the 8 data bits least significant bit first.
- R2: A control character is 4 bits in this transmission order: parity, a flag of 1, then two code bits. The code bits in sending order are 0,0 for FCT, 0,1 for EOP, 1,0 for EEP and 1,1 for ESC.
- R3: A token is expanded by this priority: time code (tok_time) is sent as ESC followed by a data character holding tok_byte; otherwise flow-control-plus-character (tok_fct_char) is sent as FCT followed by the character; otherwise flow control (tok_fct) is sent as FCT; otherwise an end marker (tok_marker) is sent as EEP when tok_byte bit 0 is 1 and as EOP when it is 0; otherwise tok_byte is sent as a data character. The second character of a pair is an end marker when tok_marker is set.
- R4: When no valid token is present as a new character must start, a NULL (ESC then FCT) is sent.
- R5: tok_taken is high for one clock, only together with tok_valid, tx_en and bit_en, exactly once per token. A token is never taken while the second half of the previous one is still pending.
- R6: The parity bit gives odd parity over the payload bits of the previous character, the current flag and itself. The payload history is cleared while disabled.
- R7: On each bit period the data line takes the next bit and the strobe becomes NOT(new data XOR old data XOR old strobe). Exactly one line changes per bit, and the lines change only on edges where bit_en is high.
- R8: While tx_en is low, each bit_en edge sets strobe to 0 and data to data AND strobe, and no token is taken.
- R9: After tx_en rises, the first character is the ESC of a NULL, even when a token is already valid.
- R10: Characters follow one another with no idle bit period. Once a session has produced its first bit, every bit_en edge while enabled produces exactly one line transition.
- R11: During reset ds_data, ds_strobe and tok_taken are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable, one bit period per high cycle |
| tx_en | input | 1 | Transmit enable |
| tok_valid | input | 1 | A token is offered on the field inputs |
| tok_time | input | 1 | Token is a time code carrying tok_byte |
| tok_fct | input | 1 | Token is a flow-control token |
| tok_fct_char | input | 1 | Token is a flow-control token followed by a character |
| tok_marker | input | 1 | Character is an end marker; tok_byte bit 0 picks EEP |
| tok_byte | input | DATA_W | Character or time value |
| tok_taken | output | 1 | The offered token is consumed at this clock edge |
| ds_data | output | 1 | Serial data line |
| ds_strobe | output | 1 | Serial strobe line |

## Verification
The bench decodes the line from its transitions alone. It rebuilds every character, checks its parity against its own history, and compares the character sequence with one it derives from the tokens. It covers bytes of all-zero, all-one and alternating patterns, both end markers, split time codes, paired FCT tokens and tokens with several type flags set. A design with a wrong priority or a missing second half would show up as a wrong or missing character. One whose parity history leaked between characters or between sessions would fail the parity comparison, and one that fetched a token too early would give a wrong tok_taken count. The bench also checks the NULL that must lead each session while a token is already offered, and the NULLs that fill the idle gap once the tokens run out. Shutdown is checked at both a slow and an every-cycle bit rate. A design that dropped both lines at once, kept taking tokens while disabled, or left a gap bit between characters would be caught.

// File: rtl/ds_ser_pkg.sv
package ds_ser_pkg;

    // Link character kinds produced by the sequencer
    typedef enum logic [2:0] {
        SYM_DATA,
        SYM_FCT,
        SYM_EOP,
        SYM_EEP,
        SYM_ESC
    } sym_e;

    // Second half still owed after the current character
    typedef enum logic [1:0] {
        HALF_NONE,
        HALF_FCT,
        HALF_TIME,
        HALF_CHAR
    } half_e;

    localparam int CTRL_BITS = 4;

    // Two code bits of a control character, {second sent, first sent}
    function automatic logic [1:0] ctrl_code(sym_e kind);
        logic [1:0] code;
        case (kind)
            SYM_FCT: code = 2'b00;
            SYM_EOP: code = 2'b10;
            SYM_EEP: code = 2'b01;
            default: code = 2'b11;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/ds_sequencer.sv
module ds_sequencer
    import ds_ser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              load,
    input  logic              tok_valid,
    input  logic              tok_time,
    input  logic              tok_fct,
    input  logic              tok_fct_char,
    input  logic              tok_marker,
    input  logic [DATA_W-1:0] tok_byte,
    output sym_e              sym_kind,
    output logic [DATA_W-1:0] sym_byte,
    output logic              tok_taken
);

    typedef struct packed {
        logic              fresh;
        half_e             half;
        logic [DATA_W-1:0] held_byte;
        logic              held_marker;
    } seq_t;

    localparam seq_t SEQ_IDLE = '{fresh: 1'b1, half: HALF_NONE,
                                  held_byte: '0, held_marker: 1'b0};

    seq_t st_q, st_d;
    logic take;

    // Marker selection shared by direct and deferred characters
    function automatic sym_e marker_kind(logic [DATA_W-1:0] b);
        return b[0] ? SYM_EEP : SYM_EOP;
    endfunction

    always_comb begin
        seq_t nx;
        nx       = st_q;
        sym_kind = SYM_ESC;
        sym_byte = st_q.held_byte;
        take     = 1'b0;

        if (st_q.fresh) begin
            // session opener: ESC of a NULL, FCT owed
            nx.fresh = 1'b0;
            nx.half  = HALF_FCT;
        end else begin
            case (st_q.half)
                HALF_FCT: begin
                    sym_kind = SYM_FCT;
                    nx.half  = HALF_NONE;
                end
                HALF_TIME: begin
                    sym_kind = SYM_DATA;
                    nx.half  = HALF_NONE;
                end
                HALF_CHAR: begin
                    sym_kind = st_q.held_marker ? marker_kind(st_q.held_byte) : SYM_DATA;
                    nx.half  = HALF_NONE;
                end
                default: begin
                    if (tok_valid) begin
                        take = 1'b1;
                        if (tok_time) begin
                            sym_kind     = SYM_ESC;
                            nx.half      = HALF_TIME;
                            nx.held_byte = tok_byte;
                        end else if (tok_fct_char) begin
                            sym_kind       = SYM_FCT;
                            nx.half        = HALF_CHAR;
                            nx.held_byte   = tok_byte;
                            nx.held_marker = tok_marker;
                        end else if (tok_fct) begin
                            sym_kind = SYM_FCT;
                        end else if (tok_marker) begin
                            sym_kind = marker_kind(tok_byte);
                        end else begin
                            sym_kind = SYM_DATA;
                            sym_byte = tok_byte;
                        end
                    end else begin
                        // filler NULL
                        sym_kind = SYM_ESC;
                        nx.half  = HALF_FCT;
                    end
                end
            endcase
        end

        if (!tx_en) begin
            st_d = SEQ_IDLE;
        end else if (load) begin
            st_d = nx;
        end else begin
            st_d = st_q;
        end
    end

    assign tok_taken = load & take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ds_shifter.sv
module ds_shifter
    import ds_ser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_en,
    input  sym_e              sym_kind,
    input  logic [DATA_W-1:0] sym_byte,
    output logic              load,
    output logic              cur_bit,
    output logic              cur_valid
);

    localparam int SH_W = DATA_W + 2;

    typedef struct packed {
        logic [SH_W-1:0] shift;
        logic [SH_W-1:0] left;   // one-hot: bits still to send
        logic            valid;
        logic            hist;   // XOR of previous character payload
    } sh_t;

    sh_t st_q, st_d;

    assign load      = tx_en & bit_en & (st_q.left[0] | ~st_q.valid);
    assign cur_bit   = st_q.shift[0];
    assign cur_valid = st_q.valid;

    always_comb begin
        logic [1:0] code;
        logic       par;
        st_d = st_q;
        code = ctrl_code(sym_kind);
        par  = 1'b0;

        if (!tx_en) begin
            st_d = '0;
        end else if (load) begin
            st_d.valid = 1'b1;
            if (sym_kind == SYM_DATA) begin
                par        = ~st_q.hist;
                st_d.shift = {sym_byte, 1'b0, par};
                st_d.left  = {1'b1, {(SH_W-1){1'b0}}};
                st_d.hist  = ^sym_byte;
            end else begin
                par        = st_q.hist;
                st_d.shift = {{(SH_W-CTRL_BITS){1'b0}}, code, 1'b1, par};
                st_d.left  = {{(SH_W-1){1'b0}}, 1'b1} << (CTRL_BITS - 1);
                st_d.hist  = ^code;
            end
        end else if (bit_en) begin
            st_d.shift = {1'b0, st_q.shift[SH_W-1:1]};
            st_d.left  = {1'b0, st_q.left[SH_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ds_line.sv
module ds_line (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic cur_valid,
    input  logic cur_bit,
    output logic ds_data,
    output logic ds_strobe
);

    typedef struct packed {
        logic d;
        logic s;
    } line_t;

    line_t ln_q, ln_d;

    always_comb begin
        ln_d = ln_q;
        if (bit_en) begin
            if (cur_valid) begin
                ln_d.d = cur_bit;
                ln_d.s = ~(cur_bit ^ ln_q.d ^ ln_q.s);
            end else begin
                // drain: strobe first, then data
                ln_d.d = ln_q.d & ln_q.s;
                ln_d.s = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign ds_data   = ln_q.d;
    assign ds_strobe = ln_q.s;

endmodule

// File: rtl/ds_serializer.sv
module ds_serializer
    import ds_ser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_en,
    input  logic              tok_valid,
    input  logic              tok_time,
    input  logic              tok_fct,
    input  logic              tok_fct_char,
    input  logic              tok_marker,
    input  logic [DATA_W-1:0] tok_byte,
    output logic              tok_taken,
    output logic              ds_data,
    output logic              ds_strobe
);

    sym_e              sym_kind;
    logic [DATA_W-1:0] sym_byte;
    logic              load;
    logic              cur_bit;
    logic              cur_valid;

    ds_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (tx_en),
        .load         (load),
        .tok_valid    (tok_valid),
        .tok_time     (tok_time),
        .tok_fct      (tok_fct),
        .tok_fct_char (tok_fct_char),
        .tok_marker   (tok_marker),
        .tok_byte     (tok_byte),
        .sym_kind     (sym_kind),
        .sym_byte     (sym_byte),
        .tok_taken    (tok_taken)
    );

    ds_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .bit_en    (bit_en),
        .sym_kind  (sym_kind),
        .sym_byte  (sym_byte),
        .load      (load),
        .cur_bit   (cur_bit),
        .cur_valid (cur_valid)
    );

    ds_line u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .cur_valid (cur_valid),
        .cur_bit   (cur_bit),
        .ds_data   (ds_data),
        .ds_strobe (ds_strobe)
    );

endmodule

// File: rtl/ds_serializer_chk.sv
module ds_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_en,
    input logic tok_valid,
    input logic tok_taken,
    input logic ds_data,
    input logic ds_strobe
);

    // R7
    one_line_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !((ds_data != $past(ds_data)) && (ds_strobe != $past(ds_strobe))));

    // R7
    lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ds_data) && $stable(ds_strobe)));

    // R8
    off_strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && $past(!tx_en) && bit_en) |=> !ds_strobe);

    // R8
    off_data_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && $past(!tx_en) && bit_en && !ds_strobe) |=> !ds_data);

    // R5
    take_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_taken |-> (tok_valid && tx_en && bit_en));

    // R9
    no_take_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> !tok_taken);

endmodule

bind ds_serializer ds_serializer_chk u_chk (.*);

// File: tb/ds_serializer_bench.sv
module ds_serializer_bench;

    localparam int SYM_FCT = 256;
    localparam int SYM_EOP = 257;
    localparam int SYM_EEP = 258;
    localparam int SYM_ESC = 259;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       tok_valid = 1'b0;
    logic       tok_time = 1'b0;
    logic       tok_fct = 1'b0;
    logic       tok_fct_char = 1'b0;
    logic       tok_marker = 1'b0;
    logic [7:0] tok_byte = 8'h00;
    logic       tok_taken;
    logic       ds_data;
    logic       ds_strobe;

    ds_serializer u_ds_serializer (
        .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .tx_en (tx_en),
        .tok_valid (tok_valid), .tok_time (tok_time), .tok_fct (tok_fct),
        .tok_fct_char (tok_fct_char), .tok_marker (tok_marker),
        .tok_byte (tok_byte), .tok_taken (tok_taken),
        .ds_data (ds_data), .ds_strobe (ds_strobe)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int div = 3;
    int phase = 0;
    int takes = 0;
    int exp_q[$];
    logic [11:0] tok_list[$];   // {time, fct_char, fct, marker, byte}

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // bit-rate enable generator
    always @(negedge clk) begin
        if (phase >= div - 1) phase = 0;
        else phase = phase + 1;
        bit_en = (phase == 0);
    end

    logic en_seen = 1'b0;
    logic ten_seen = 1'b0;
    always @(posedge clk) begin
        en_seen  <= bit_en;
        ten_seen <= tx_en;
        if (tok_taken) takes <= takes + 1;
    end

    // monitor: decodes characters from line transitions
    logic mon_on = 1'b0;
    logic mon_prev = 1'b0;
    logic pd = 1'b0, ps = 1'b0;
    logic started = 1'b0;
    logic acc_m = 1'b0;
    logic [9:0] cbits;
    int nb = 0;

    always @(negedge clk) begin
        logic cd, cs;
        int len, sym;
        logic pay;
        cd = (ds_data != pd);
        cs = (ds_strobe != ps);
        if (rst_n && (cd || cs))
            chk(!(cd && cs), "R7 both lines moved", 2, 1);
        if (mon_on && !mon_prev) begin
            nb = 0; acc_m = 1'b0; started = 1'b0;
        end
        if (mon_on) begin
            if (started && en_seen && ten_seen)
                chk(cd ^ cs, "R10 gap bit", int'(cd) + int'(cs), 1);
            if (cd || cs) begin
                started = 1'b1;
                cbits[nb] = ds_data;
                nb++;
                len = (nb >= 2 && cbits[1]) ? 4 : 10;
                if (nb == len) begin
                    chk(cbits[0] == ~(acc_m ^ cbits[1]), "R6 parity",
                        int'(cbits[0]), int'(~(acc_m ^ cbits[1])));
                    if (cbits[1]) begin
                        case ({cbits[3], cbits[2]})
                            2'b00:   sym = SYM_FCT;
                            2'b10:   sym = SYM_EOP;
                            2'b01:   sym = SYM_EEP;
                            default: sym = SYM_ESC;
                        endcase
                        pay = cbits[2] ^ cbits[3];
                    end else begin
                        sym = int'(cbits[9:2]);
                        pay = ^cbits[9:2];
                    end
                    acc_m = pay;
                    if (exp_q.size() > 0) begin
                        chk(sym == exp_q[0], "R1 R2 R3 R4 R9 character", sym, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                    nb = 0;
                end
            end
        end
        mon_prev = mon_on;
        pd = ds_data;
        ps = ds_strobe;
    end

    task automatic push_expect(logic [11:0] t);
        int ch;
        ch = t[8] ? (t[0] ? SYM_EEP : SYM_EOP) : int'(t[7:0]);
        if (t[11]) begin
            exp_q.push_back(SYM_ESC); exp_q.push_back(int'(t[7:0]));
        end else if (t[10]) begin
            exp_q.push_back(SYM_FCT); exp_q.push_back(ch);
        end else if (t[9]) begin
            exp_q.push_back(SYM_FCT);
        end else begin
            exp_q.push_back(ch);
        end
    endtask

    task automatic present(logic [11:0] t);
        tok_time = t[11]; tok_fct_char = t[10]; tok_fct = t[9];
        tok_marker = t[8]; tok_byte = t[7:0];
    endtask

    task automatic run_burst(int div_v, int nulls);
        int base;
        div = div_v;
        // R9: session always opens with a NULL
        exp_q.push_back(SYM_ESC); exp_q.push_back(SYM_FCT);
        foreach (tok_list[i]) push_expect(tok_list[i]);
        // R4: idle filler after the last token
        for (int k = 0; k < nulls; k++) begin
            exp_q.push_back(SYM_ESC); exp_q.push_back(SYM_FCT);
        end
        @(negedge clk);
        base = takes;
        mon_on = 1'b1;
        present(tok_list[0]);
        tok_valid = 1'b1;
        tx_en = 1'b1;
        for (int i = 0; i < tok_list.size(); i++) begin
            present(tok_list[i]);
            #1;
            while (!tok_taken) begin
                @(negedge clk); #1;
            end
            @(posedge clk);
            @(negedge clk);
        end
        tok_valid = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        mon_on = 1'b0;
        // R5: one take per token
        chk(takes - base == tok_list.size(), "R5 take count", takes - base, tok_list.size());
    endtask

    task automatic shut_down();
        int hits;
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        do @(negedge clk); while (!en_seen);
        chk(ds_strobe == 1'b0, "R8 strobe drops first", int'(ds_strobe), 0);
        do @(negedge clk); while (!en_seen);
        chk(ds_data == 1'b0, "R8 data drains", int'(ds_data), 0);
        // R8: offered token ignored while disabled
        present(12'h0_42);
        tok_valid = 1'b1;
        hits = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            if (tok_taken || ds_data || ds_strobe) hits++;
        end
        chk(hits == 0, "R8 disabled quiet", hits, 0);
        tok_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(ds_data == 1'b0 && ds_strobe == 1'b0, "R11 lines in reset",
            int'({ds_data, ds_strobe}), 0);
        chk(tok_taken == 1'b0, "R11 no take in reset", int'(tok_taken), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(ds_data == 1'b0 && ds_strobe == 1'b0, "R8 idle after reset",
            int'({ds_data, ds_strobe}), 0);

        // burst 1: slow bit rate, R1 R2 R3 patterns
        tok_list = {12'h0_00, 12'h0_A5, 12'h0_FF, 12'h2_00, 12'h1_00, 12'h1_01,
                    12'h8_3C, 12'h4_81, 12'h5_01, 12'hA_5A, 12'h3_10, 12'h0_01};
        run_burst(3, 2);
        shut_down();

        // burst 2: bit_en every cycle, parity history restarts (R6)
        tok_list = {12'h0_5A, 12'h0_01, 12'h5_00, 12'h8_07, 12'h0_80, 12'h2_00};
        run_burst(1, 1);
        shut_down();

        finish_run();
    end

endmodule